// File: doc/BRIEF.md
# Banked Memory Address Extender

This block lets an 8-bit processor with a 16-bit address bus reach a 512K physical memory. The 64K logical space is divided into eight 8K pages. The page number of each access is formed by adding a software-loaded base value to the top three logical address bits. The low 13 bits pass through unchanged. The topmost logical page is pinned to the highest physical page, so it gives a common area that never moves when the base changes. Leaving out that common page, the 512K space holds nine 56K banks.

A boot ROM of 32K can be overlaid on the lower logical half. Reset turns the overlay on and clears the base. Boot code can then copy itself into high RAM, jump there and switch the overlay off through an I/O write. The base value and the overlay bit are loaded by I/O writes to two port numbers.

The block has no data stream. The processor strobes are plain active-low control pins, and the block applies no back-pressure. The outputs are combinational in the address and strobes. Register updates take effect on the rising clock edge that samples an I/O write.

Top module: `bank_mapper`

## Requirements
- R1: `phys_addr[12:0]` always equals `cpu_addr[12:0]`.
- R2: When `cpu_addr[15:13]` is not 3'b111, `phys_addr[18:13]` equals the low six bits of (base + `cpu_addr[15:13]`). Any carry beyond bit 5 is dropped, so pages wrap modulo 64.
- R3: When `cpu_addr[15:13]` is 3'b111, `phys_addr[18:13]` is 6'h3F for every base value.
- R4: A rising clock edge that sees `iorq_n`=0, `wr_n`=0 and `cpu_addr[7:0]`=8'h40 loads the 8-bit base from `data_in`. The new value is used from the following cycle.
- R5: A rising clock edge that sees `iorq_n`=0, `wr_n`=0 and `cpu_addr[7:0]`=8'h41 sets the ROM overlay to `data_in[0]`, where 1 means enabled.
- R6: With the overlay enabled, `mreq_n`=0 and `cpu_addr[15]`=0, `rom_cs_n` is 0 and `ram_cs_n` is 1.
- R7: With `mreq_n`=0 and the ROM not selected, `ram_cs_n` is 0 and `rom_cs_n` is 1.
- R8: With `mreq_n`=1, both `ram_cs_n` and `rom_cs_n` are 1.
- R9: Reset (`rst_n`=0) clears the base to 0 and enables the ROM overlay.
- R10: Neither register changes on I/O reads, on I/O writes to other port numbers, or on memory cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; register loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical address; bits [7:0] carry the port number in I/O cycles |
| mreq_n | input | 1 | Active-low memory request |
| iorq_n | input | 1 | Active-low I/O request |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Processor data bus as seen by the block |
| phys_addr | output | 19 | Extended physical address |
| ram_cs_n | output | 1 | Active-low RAM select |
| rom_cs_n | output | 1 | Active-low ROM select |

## Verification
The bench builds the block with its default parameters: a 16-bit logical bus, a 19-bit physical bus, an 8-bit base and the explicit ripple-carry page adder. With these values, base writes near 8'hFF and 8'h3F reach the page wrap and the overflow into the unused upper bits. The fixed-seed random mix interleaves base writes, overlay writes, foreign-port writes, I/O reads and memory cycles. This covers the common page under every base and lets the overlay switch on and off between accesses.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned LOG_AW  = 16;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned PAGE_SW = 3;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RAM  = 2'd1,
    ACC_ROM  = 2'd2
  } access_kind_t;

  function automatic logic is_io_write(input logic iorq_n, input logic wr_n);
    return (!iorq_n) && (!wr_n);
  endfunction
endpackage

// File: rtl/bm_port_regs.sv
module bm_port_regs #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BASE_W    = 8,
  parameter int unsigned PORT_W    = 8,
  parameter logic [7:0]  BASE_PORT = 8'h40,
  parameter logic [7:0]  ROM_PORT  = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_num,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [BASE_W-1:0] base_q,
  output logic              romen_q
);
  import bank_mapper_pkg::*;

  localparam int unsigned CPY_W = (BASE_W < DATA_W) ? BASE_W : DATA_W;

  logic io_wr;
  logic hit_base;
  logic hit_rom;
  logic [BASE_W-1:0] base_nxt;

  assign io_wr    = is_io_write(iorq_n, wr_n);
  assign hit_base = io_wr && (port_num == BASE_PORT[PORT_W-1:0]);
  assign hit_rom  = io_wr && (port_num == ROM_PORT[PORT_W-1:0]);

  always_comb begin
    base_nxt = '0;
    base_nxt[CPY_W-1:0] = data_in[CPY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      romen_q <= 1'b1;
    end else begin
      if (hit_base) base_q  <= base_nxt;
      if (hit_rom)  romen_q <= data_in[0];
    end
  end
endmodule

// File: rtl/bm_page_adder.sv
module bm_page_adder #(
  parameter int unsigned W     = 8,
  parameter int unsigned STYLE = 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  generate
    if (STYLE == 1) begin : g_ripple
      logic [W:0] cy;
      logic unused_cout;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
      end
      assign unused_cout = cy[W];
    end else begin : g_behav
      assign sum = a + b;
    end
  endgenerate
endmodule

// File: rtl/bm_select_decode.sv
module bm_select_decode #(
  parameter int unsigned PAGE_W  = 6,
  parameter int unsigned PAGE_SW = 3
) (
  input  logic               mreq_n,
  input  logic               romen,
  input  logic [PAGE_SW-1:0] cpu_page,
  input  logic [PAGE_W-1:0]  sum_page,
  output logic [PAGE_W-1:0]  phys_page,
  output logic               ram_cs_n,
  output logic               rom_cs_n
);
  import bank_mapper_pkg::*;

  access_kind_t kind;
  logic in_common;
  logic low_half;

  assign in_common = &cpu_page;
  assign low_half  = ~cpu_page[PAGE_SW-1];
  assign phys_page = in_common ? {PAGE_W{1'b1}} : sum_page;

  always_comb begin
    if (mreq_n)                kind = ACC_IDLE;
    else if (romen && low_half) kind = ACC_ROM;
    else                       kind = ACC_RAM;
  end

  assign ram_cs_n = (kind != ACC_RAM);
  assign rom_cs_n = (kind != ACC_ROM);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int unsigned PHYS_AW     = 19,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BASE_W      = 8,
  parameter int unsigned ADDER_STYLE = 1,
  parameter logic [7:0]  BASE_PORT   = 8'h40,
  parameter logic [7:0]  ROM_PORT    = 8'h41
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [bank_mapper_pkg::LOG_AW-1:0] cpu_addr,
  input  logic                           mreq_n,
  input  logic                           iorq_n,
  input  logic                           wr_n,
  input  logic [DATA_W-1:0]              data_in,
  output logic [PHYS_AW-1:0]             phys_addr,
  output logic                           ram_cs_n,
  output logic                           rom_cs_n
);
  import bank_mapper_pkg::*;

  localparam int unsigned OFS_W  = LOG_AW - PAGE_SW;
  localparam int unsigned PAGE_W = PHYS_AW - OFS_W;

  logic [BASE_W-1:0]  base_q;
  logic               romen_q;
  logic [BASE_W-1:0]  add_b;
  logic [BASE_W-1:0]  sum_full;
  logic [PAGE_W-1:0]  phys_page;
  logic [PAGE_SW-1:0] cpu_page;
  logic               unused_sum_hi;

  assign cpu_page = cpu_addr[LOG_AW-1:OFS_W];

  bm_port_regs #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .PORT_W(PORT_W),
    .BASE_PORT(BASE_PORT), .ROM_PORT(ROM_PORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .port_num(cpu_addr[PORT_W-1:0]),
    .iorq_n(iorq_n), .wr_n(wr_n), .data_in(data_in),
    .base_q(base_q), .romen_q(romen_q)
  );

  always_comb begin
    add_b = '0;
    add_b[PAGE_SW-1:0] = cpu_page;
  end

  bm_page_adder #(.W(BASE_W), .STYLE(ADDER_STYLE)) u_add (
    .a(base_q), .b(add_b), .sum(sum_full)
  );

  assign unused_sum_hi = ^sum_full[BASE_W-1:PAGE_W];

  bm_select_decode #(.PAGE_W(PAGE_W), .PAGE_SW(PAGE_SW)) u_dec (
    .mreq_n(mreq_n), .romen(romen_q), .cpu_page(cpu_page),
    .sum_page(sum_full[PAGE_W-1:0]), .phys_page(phys_page),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n)
  );

  assign phys_addr = {phys_page, cpu_addr[OFS_W-1:0]};
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        mreq_n,
  input logic        iorq_n,
  input logic        wr_n,
  input logic [7:0]  data_in,
  input logic [18:0] phys_addr,
  input logic        ram_cs_n,
  input logic        rom_cs_n,
  input logic [7:0]  base_q,
  input logic        romen_q
);
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[12:0] == cpu_addr[12:0]);

  p_common_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (phys_addr[18:13] == 6'h3F));

  p_base_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !wr_n && cpu_addr[7:0] == 8'h40) |=> (base_q == $past(data_in)));

  p_rom_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !wr_n && cpu_addr[7:0] == 8'h41) |=> (romen_q == $past(data_in[0])));

  p_rom_overlay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && romen_q && !cpu_addr[15]) |-> (!rom_cs_n && ram_cs_n));

  p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_cs_n, ~rom_cs_n}) == (mreq_n ? 0 : 1));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (ram_cs_n && rom_cs_n));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n || wr_n) |=> ($stable(base_q) && $stable(romen_q)));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
  .iorq_n(iorq_n), .wr_n(wr_n), .data_in(data_in), .phys_addr(phys_addr),
  .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .base_q(base_q), .romen_q(romen_q)
);

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mreq_n = 1'b1;
  logic        iorq_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  data_in = '0;
  logic [18:0] phys_addr;
  logic        ram_cs_n;
  logic        rom_cs_n;

  int errors = 0;
  int checks = 0;
  logic [7:0] base_m = 8'h00;
  logic       rom_m  = 1'b1;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .wr_n(wr_n), .data_in(data_in), .phys_addr(phys_addr),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n)
  );

  function automatic logic [18:0] exp_phys(input logic [7:0] b, input logic [15:0] a);
    logic [7:0] s;
    s = b + {5'd0, a[15:13]};
    if (a[15:13] == 3'b111) return {6'h3F, a[12:0]};
    return {s[5:0], a[12:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_cycle(input logic [7:0] port, input logic [7:0] d, input logic wr);
    @(negedge clk);
    cpu_addr = {8'h00, port};
    data_in  = d;
    iorq_n   = 1'b0;
    wr_n     = ~wr;
    @(posedge clk);
    #1;
    if (wr && port == 8'h40) base_m = d;
    if (wr && port == 8'h41) rom_m = d[0];
    @(negedge clk);
    iorq_n = 1'b1;
    wr_n   = 1'b1;
  endtask

  task automatic mem_cycle(input logic [15:0] a, input logic wr, input logic [7:0] d, input string req);
    logic r;
    @(negedge clk);
    cpu_addr = a;
    data_in  = d;
    mreq_n   = 1'b0;
    wr_n     = ~wr;
    #1;
    r = rom_m && !a[15];
    check({req, " addr"}, {13'd0, phys_addr}, {13'd0, exp_phys(base_m, a)});
    check({req, " rom_cs_n"}, {31'd0, rom_cs_n}, {31'd0, ~r});
    check({req, " ram_cs_n"}, {31'd0, ram_cs_n}, {31'd0, r});
    @(posedge clk);
    #1;
    mreq_n = 1'b1;
    wr_n   = 1'b1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: idle selects during and after reset
    check("R8 idle ram", {31'd0, ram_cs_n}, 32'd1);
    check("R8 idle rom", {31'd0, rom_cs_n}, 32'd1);
    rst_n = 1'b1;
    // R9: reset leaves base 0 and overlay enabled
    mem_cycle(16'h1234, 1'b0, 8'h00, "R9 reset rom");
    mem_cycle(16'h8ABC, 1'b0, 8'h00, "R9 reset base");
    // R6 / R1
    mem_cycle(16'h7FFF, 1'b0, 8'h00, "R6 rom top R1");
    // R4 + R2 wrap: base FE + page 5 -> 0x103 -> page 3
    io_cycle(8'h40, 8'hFE, 1'b1);
    mem_cycle(16'hA001, 1'b0, 8'h00, "R2 wrap R4");
    // R3 common page under any base
    mem_cycle(16'hE555, 1'b0, 8'h00, "R3 common");
    io_cycle(8'h40, 8'h3F, 1'b1);
    mem_cycle(16'h0000 | 16'h8000, 1'b0, 8'h00, "R2 page4 base3F");
    mem_cycle(16'hFFFF, 1'b0, 8'h00, "R3 common top");
    // R5 turn overlay off; R7 RAM in low half
    io_cycle(8'h41, 8'h00, 1'b1);
    mem_cycle(16'h0100, 1'b0, 8'h00, "R5 R7 rom off");
    // R10: foreign port write, I/O read, memory writes leave state
    io_cycle(8'h42, 8'h11, 1'b1);
    io_cycle(8'h40, 8'h22, 1'b0);
    io_cycle(8'h41, 8'h01, 1'b0);
    mem_cycle(16'h0040, 1'b1, 8'h01, "R10 mem wr");
    mem_cycle(16'h2000, 1'b0, 8'h00, "R10 state kept");
    io_cycle(8'h41, 8'h01, 1'b1);
    mem_cycle(16'h4000, 1'b0, 8'h00, "R5 rom back on");

    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: io_cycle(8'h40, 8'($urandom), 1'b1);
        1: io_cycle(8'h41, 8'($urandom), 1'b1);
        2: io_cycle(8'($urandom_range(0, 255)) | 8'h80, 8'($urandom), 1'b1);
        3: io_cycle(8'h40 + 8'($urandom_range(0, 1)), 8'($urandom), 1'b0);
        default: mem_cycle(16'($urandom), 1'($urandom), 8'($urandom), "R2 R3 R6 R7 R10 random");
      endcase
    end
    @(negedge clk);
    check("R8 idle end", {30'd0, ram_cs_n, rom_cs_n}, 32'd3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule